// File: doc/BRIEF.md
# Logarithmic-Domain Adder with Interpolated Correction

This block adds two positive real numbers that are carried as base-2 logarithms. Each operand is a signed two's-complement fixed-point value. The result is the fixed-point logarithm of the sum. The block is used wherever a datapath works in the log domain, so that multiplies are plain additions, but it still needs true sums now and then.

The computation keeps the larger operand as the base. It takes the argument z as minus the absolute difference of the two operands, so z is never positive. It then adds the correction log2(1 + 2^z) to the base.

The correction is read from a pair of tables addressed by the coarse part of z:
- one table holds the value of the correction at each grid point;
- the other holds the chord slope to the next grid point.

The fine part of z is multiplied by the slope and added to the value.

When z falls below the cutoff, the correction is too small to matter. In that case the larger operand is passed through with no table term. The tables are filled with computed values at elaboration time and are read synchronously. Operands enter through a valid/ready handshake. The result leaves from a registered output stage.

Top module: `lns_add`

## Requirements
- R1: Operands and result are 18-bit two's-complement codes with 12 fractional bits. A code v stands for the real 2^(v/4096). For operands whose result fits, the result code divided by 4096 is within 1/4096 of log2(2^(a/4096) + 2^(b/4096)).
- R2: Swapping the two operands gives exactly the same result code.
- R3: When both operands are equal and the result fits, the result is exactly the operand code plus 4096.
- R4: When the absolute difference of the operand codes exceeds 57216 (13.96875 in real terms), the result equals the larger operand code exactly.
- R5: Every result code lies between the larger operand code and that code plus 4096, inclusive.
- R6: When the rounded sum would exceed 131071, the result is 131071.
- R7: While out_valid is high and out_ready is low, out_sum and out_valid hold. Once both pipeline stages are occupied in that state, in_ready is low. Results leave in the order the operands were accepted.
- R8: With out_ready held high, an operand pair accepted at one clock edge has its result shown with out_valid high after the next clock edge. One pair can be accepted on every cycle.
- R9: After reset, out_valid is low and in_ready is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Operand pair present |
| in_ready | output | 1 | Block can take an operand pair this cycle |
| in_a | input | 18 | First operand, log2 code with 12 fractional bits |
| in_b | input | 18 | Second operand, log2 code with 12 fractional bits |
| out_valid | output | 1 | Result present |
| out_ready | input | 1 | Consumer takes the result this cycle |
| out_sum | output | 18 | Log2 code of the sum |

## Verification
The assertions assume that the consumer obeys the handshake. They also assume that operand codes are ordinary two's-complement values, so that the rounded sum stays non-negative relative to the larger operand. The bounds checks rely only on the larger operand carried down the pipeline. The directed stimulus keeps operands in ranges where the true sum is representable, except in the saturation scenario, which drives the top code on purpose. Stalls are produced only by dropping out_ready while results are pending, never by changing inputs that have already been accepted.

// File: rtl/lns_pkg.sv
package lns_pkg;
  // log2(1 + 2^z) evaluated in real arithmetic for table construction
  function automatic real sb2(input real z);
    return $ln(1.0 + (2.0 ** z)) / $ln(2.0);
  endfunction
endpackage

// File: rtl/lns_sb_rom.sv
module lns_sb_rom #(
  parameter int HI_W    = 5,
  parameter int FRAC_W  = 12,
  parameter int GUARD_W = 2,
  parameter int SLOPE_W = 10,
  parameter int DEPTH   = 448,
  parameter int AW      = 9,
  parameter int IW      = 15
) (
  input  logic          clk,
  input  logic          rd_en,
  input  logic [AW-1:0] addr,
  output logic [IW-1:0] icpt_q,
  output logic [SLOPE_W-1:0] slope_q
);
  logic [IW-1:0]      icpt_mem  [DEPTH];
  logic [SLOPE_W-1:0] slope_mem [DEPTH];

  // grid point a sits at z = -a * 2^-HI_W; slope is the chord to the next point up
  initial begin
    real zh, s0, s1, step;
    step = 1.0 / real'(1 << HI_W);
    for (int a = 0; a < DEPTH; a++) begin
      zh = -real'(a) * step;
      s0 = lns_pkg::sb2(zh);
      s1 = lns_pkg::sb2(zh + step);
      icpt_mem[a]  = IW'($rtoi(s0 * real'(1 << (FRAC_W + GUARD_W)) + 0.5));
      slope_mem[a] = SLOPE_W'($rtoi((s1 - s0) / step * real'(1 << SLOPE_W) + 0.5));
    end
  end

  always_ff @(posedge clk) begin
    if (rd_en) begin
      icpt_q  <= icpt_mem[addr];
      slope_q <= slope_mem[addr];
    end
  end
endmodule

// File: rtl/lns_front.sv
module lns_front #(
  parameter int W      = 18,
  parameter int FRAC_W = 12,
  parameter int HI_W   = 5,
  parameter int DEPTH  = 448,
  parameter int AW     = 9
) (
  input  logic signed [W-1:0]          a,
  input  logic signed [W-1:0]          b,
  output logic signed [W-1:0]          big,
  output logic [AW-1:0]                addr,
  output logic [FRAC_W-HI_W-1:0]       zl,
  output logic                         ez
);
  localparam int LOW_W = FRAC_W - HI_W;

  logic signed [W:0] diff;
  logic [W-1:0]      mag;
  logic signed [W:0] zneg;
  logic signed [W:0] zhi;
  logic [W:0]        steps;

  always_comb begin
    diff  = {a[W-1], a} - {b[W-1], b};
    big   = diff[W] ? b : a;
    mag   = diff[W] ? W'(-diff) : W'(diff);
    zneg  = -$signed({1'b0, mag});
    zhi   = zneg >>> LOW_W;
    steps = $unsigned(-zhi);
    zl    = zneg[LOW_W-1:0];
    ez    = steps >= (W+1)'(DEPTH);
    addr  = ez ? AW'(DEPTH - 1) : steps[AW-1:0];
  end
endmodule

// File: rtl/lns_interp.sv
module lns_interp #(
  parameter int W       = 18,
  parameter int FRAC_W  = 12,
  parameter int HI_W    = 5,
  parameter int GUARD_W = 2,
  parameter int SLOPE_W = 10,
  parameter int IW      = 15
) (
  input  logic signed [W-1:0]      big,
  input  logic [IW-1:0]            icpt,
  input  logic [SLOPE_W-1:0]       slope,
  input  logic [FRAC_W-HI_W-1:0]   zl,
  input  logic                     ez,
  output logic signed [W-1:0]      res
);
  localparam int LOW_W = FRAC_W - HI_W;
  localparam int PW    = SLOPE_W + LOW_W;
  localparam int SUM_W = W + GUARD_W + 2;
  localparam logic signed [SUM_W-1:0] MAXV = SUM_W'((1 << (W-1)) - 1);
  localparam logic signed [SUM_W-1:0] HALF = SUM_W'(1 << (GUARD_W-1));

  logic [PW-1:0]           prod;
  logic [SUM_W-1:0]        corr;
  logic signed [SUM_W-1:0] acc;
  logic signed [SUM_W-1:0] rnd;

  always_comb begin
    prod = PW'(slope) * PW'(zl);
    corr = ez ? '0 : (SUM_W'(icpt) + SUM_W'(prod >> (SLOPE_W - GUARD_W)));
    acc  = (SUM_W'(big) <<< GUARD_W) + $signed(corr);
    rnd  = (acc + HALF) >>> GUARD_W;
    res  = (rnd > MAXV) ? MAXV[W-1:0] : rnd[W-1:0];
  end
endmodule

// File: rtl/lns_add.sv
module lns_add #(
  parameter int INT_W   = 6,
  parameter int FRAC_W  = 12,
  parameter int HI_W    = 5,
  parameter int GUARD_W = 2,
  parameter int SLOPE_W = 10,
  parameter int ZCUT    = 14
) (
  input  logic                        clk,
  input  logic                        rst,
  input  logic                        in_valid,
  output logic                        in_ready,
  input  logic signed [INT_W+FRAC_W-1:0] in_a,
  input  logic signed [INT_W+FRAC_W-1:0] in_b,
  output logic                        out_valid,
  input  logic                        out_ready,
  output logic signed [INT_W+FRAC_W-1:0] out_sum
);
  localparam int W     = INT_W + FRAC_W;
  localparam int DEPTH = ZCUT << HI_W;
  localparam int AW    = $clog2(DEPTH);
  localparam int IW    = FRAC_W + GUARD_W + 1;
  localparam int LOW_W = FRAC_W - HI_W;

  logic adv_out, adv_s1, accept;
  logic signed [W-1:0] f_big, s1_big, i_res;
  logic [AW-1:0]       f_addr;
  logic [LOW_W-1:0]    f_zl, s1_zl;
  logic                f_ez, s1_ez, s1_valid;
  logic [IW-1:0]       icpt_q;
  logic [SLOPE_W-1:0]  slope_q;

  assign adv_out  = !out_valid || out_ready;
  assign adv_s1   = !s1_valid || adv_out;
  assign in_ready = adv_s1;
  assign accept   = in_valid && adv_s1;

  lns_front #(.W(W), .FRAC_W(FRAC_W), .HI_W(HI_W), .DEPTH(DEPTH), .AW(AW)) u_front (
    .a(in_a), .b(in_b), .big(f_big), .addr(f_addr), .zl(f_zl), .ez(f_ez)
  );

  lns_sb_rom #(.HI_W(HI_W), .FRAC_W(FRAC_W), .GUARD_W(GUARD_W), .SLOPE_W(SLOPE_W),
               .DEPTH(DEPTH), .AW(AW), .IW(IW)) u_rom (
    .clk(clk), .rd_en(accept), .addr(f_addr), .icpt_q(icpt_q), .slope_q(slope_q)
  );

  always_ff @(posedge clk) begin
    if (rst) s1_valid <= 1'b0;
    else if (adv_s1) s1_valid <= in_valid;
    if (accept) begin
      s1_big <= f_big;
      s1_zl  <= f_zl;
      s1_ez  <= f_ez;
    end
  end

  lns_interp #(.W(W), .FRAC_W(FRAC_W), .HI_W(HI_W), .GUARD_W(GUARD_W),
               .SLOPE_W(SLOPE_W), .IW(IW)) u_interp (
    .big(s1_big), .icpt(icpt_q), .slope(slope_q), .zl(s1_zl), .ez(s1_ez), .res(i_res)
  );

  always_ff @(posedge clk) begin
    if (rst) out_valid <= 1'b0;
    else if (adv_out) out_valid <= s1_valid;
    if (adv_out && s1_valid) out_sum <= i_res;
  end

  // result bounded below by the larger operand carried from stage one
  assert_floor_R5: assert property (@(posedge clk) disable iff (rst)
    (adv_out && s1_valid) |=> (int'(out_sum) >= int'($past(s1_big))));

  // result never exceeds larger operand plus one
  assert_ceil_R5: assert property (@(posedge clk) disable iff (rst)
    (adv_out && s1_valid) |=> (int'(out_sum) <= int'($past(s1_big)) + (1 << FRAC_W)));

  // beyond the cutoff the larger operand passes through untouched
  assert_ezero_pass_R4: assert property (@(posedge clk) disable iff (rst)
    (adv_out && s1_valid && s1_ez) |=> (out_sum == $past(s1_big)));

  // a held result stays put
  assert_hold_R7: assert property (@(posedge clk) disable iff (rst)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_sum)));

  // full pipeline under backpressure refuses new operands
  assert_full_R7: assert property (@(posedge clk) disable iff (rst)
    (out_valid && !out_ready && s1_valid) |-> !in_ready);

  // an accepted pair reaches the output register after the next edge when unblocked
  assert_latency_R8: assert property (@(posedge clk) disable iff (rst)
    (accept && out_ready) |=> ##1 out_valid);
endmodule

// File: tb/lns_add_bench.sv
`timescale 1ns/1ps
module lns_add_bench;
  localparam int ONE = 4096;
  localparam int TOP = 131071;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic in_valid = 1'b0;
  logic in_ready;
  logic signed [17:0] in_a = '0;
  logic signed [17:0] in_b = '0;
  logic out_valid;
  logic out_ready = 1'b1;
  logic signed [17:0] out_sum;

  int total = 0;
  int bad = 0;
  bit done = 1'b0;
  int unsigned seed = 32'h1234_5678;

  always #4 clk = ~clk;

  lns_add u_lns_add (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_ready(in_ready),
    .in_a(in_a), .in_b(in_b), .out_valid(out_valid), .out_ready(out_ready),
    .out_sum(out_sum)
  );

  function automatic real ref_sum(input int x, input int y);
    real hi, lo;
    hi = (x > y ? x : y) / 4096.0;
    lo = (x > y ? y : x) / 4096.0;
    return hi + $ln(1.0 + (2.0 ** (lo - hi))) / $ln(2.0);
  endfunction

  function automatic int next_rand();
    seed = seed * 32'd1664525 + 32'd1013904223;
    return int'(seed >> 8);
  endfunction

  task automatic check_eq(input string tag, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic check_close(input string tag, input int x, input int y, input int act);
    real r;
    r = ref_sum(x, y);
    total++;
    if (((act / 4096.0) - r) > (1.0 / 4096.0 + 1e-9) || (r - (act / 4096.0)) > (1.0 / 4096.0 + 1e-9)) begin
      bad++;
      $display("FAIL %s a=%0d b=%0d actual=%0d expected=%f", tag, x, y, act, r * 4096.0);
    end
  endtask

  // one operation: drive, wait for acceptance, wait for the result
  task automatic run_one(input int x, input int y, output int r);
    @(negedge clk);
    out_ready = 1'b1;
    in_valid = 1'b1;
    in_a = 18'(x);
    in_b = 18'(y);
    while (!in_ready) @(negedge clk);
    @(negedge clk);
    in_valid = 1'b0;
    while (!out_valid) @(negedge clk);
    r = int'(out_sum);
  endtask

  task automatic t_reset_R9();
    @(negedge clk);
    check_eq("R9 out_valid after reset", int'(out_valid), 0);
    check_eq("R9 in_ready after reset", int'(in_ready), 1);
  endtask

  task automatic t_equal_R3();
    int r;
    int vals[4] = '{0, 5 * ONE, -7 * ONE + 123, 30 * ONE};
    foreach (vals[i]) begin
      run_one(vals[i], vals[i], r);
      check_eq("R3 equal operands", r, vals[i] + ONE);
    end
  endtask

  task automatic t_sweep_R1();
    int r;
    for (int i = 0; i < 200; i++) begin
      int x, d, y;
      x = (next_rand() % (24 * ONE)) - 12 * ONE;
      d = next_rand() % (16 * ONE);
      y = (next_rand() % 2 == 0) ? x - d : x + d;
      run_one(x, y, r);
      check_close("R1 sum accuracy", x, y, r);
    end
  endtask

  task automatic t_commute_R2();
    int r1, r2;
    for (int i = 0; i < 20; i++) begin
      int x, y;
      x = (next_rand() % (20 * ONE)) - 10 * ONE;
      y = (next_rand() % (20 * ONE)) - 10 * ONE;
      run_one(x, y, r1);
      run_one(y, x, r2);
      check_eq("R2 operand swap", r2, r1);
    end
  endtask

  task automatic t_ezero_R4();
    int r;
    run_one(3 * ONE, 3 * ONE - 57217, r);
    check_eq("R4 just past cutoff", r, 3 * ONE);
    run_one(-2 * ONE - 57217, -2 * ONE, r);
    check_eq("R4 just past cutoff swapped", r, -2 * ONE);
    run_one(10 * ONE, -131072, r);
    check_eq("R4 far apart", r, 10 * ONE);
    run_one(3 * ONE, 3 * ONE - 57216, r);
    check_close("R1 at last table point", 3 * ONE, 3 * ONE - 57216, r);
  endtask

  task automatic t_sat_R6();
    int r;
    run_one(TOP, TOP, r);
    check_eq("R6 saturate equal top", r, TOP);
    run_one(TOP, TOP - ONE, r);
    check_eq("R6 saturate near top", r, TOP);
    run_one(-131072, -131072, r);
    check_eq("R3 most negative pair", r, -131072 + ONE);
  endtask

  task automatic t_stream_R8();
    @(negedge clk);
    out_ready = 1'b1;
    in_valid = 1'b1;
    in_a = 18'(1 * ONE); in_b = 18'(1 * ONE);
    @(negedge clk);
    check_eq("R8 not yet valid one edge after accept", int'(out_valid), 0);
    check_eq("R8 ready while streaming", int'(in_ready), 1);
    in_a = 18'(2 * ONE); in_b = 18'(2 * ONE);
    for (int k = 0; k < 3; k++) begin
      @(negedge clk);
      check_eq("R8 valid in stream", int'(out_valid), 1);
      check_eq("R8 streamed result", int'(out_sum), (k + 2) * ONE);
      in_a = 18'((k + 3) * ONE); in_b = 18'((k + 3) * ONE);
    end
    in_valid = 1'b0;
    @(negedge clk);
    check_eq("R8 last streamed result", int'(out_sum), 5 * ONE);
    @(negedge clk);
    @(negedge clk);
    check_eq("R8 drains", int'(out_valid), 0);
  endtask

  task automatic t_stall_R7();
    @(negedge clk);
    out_ready = 1'b0;
    in_valid = 1'b1;
    in_a = 18'(4 * ONE); in_b = 18'(4 * ONE);
    @(negedge clk);
    in_a = 18'(6 * ONE); in_b = 18'(6 * ONE);
    @(negedge clk);
    in_a = 18'(8 * ONE); in_b = 18'(8 * ONE);
    check_eq("R7 ready low when full", int'(in_ready), 0);
    check_eq("R7 first result held", int'(out_sum), 5 * ONE);
    repeat (3) @(negedge clk);
    check_eq("R7 valid kept under stall", int'(out_valid), 1);
    check_eq("R7 result stable under stall", int'(out_sum), 5 * ONE);
    check_eq("R7 ready still low", int'(in_ready), 0);
    out_ready = 1'b1;
    @(negedge clk);
    in_valid = 1'b0;
    check_eq("R7 second result in order", int'(out_sum), 7 * ONE);
    @(negedge clk);
    check_eq("R7 third result in order", int'(out_sum), 9 * ONE);
    @(negedge clk);
    check_eq("R7 drained", int'(out_valid), 0);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    t_reset_R9();
    t_equal_R3();
    t_sweep_R1();
    t_commute_R2();
    t_ezero_R4();
    t_sat_R6();
    t_stream_R8();
    t_stall_R7();
    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog expired");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule